// File: doc/BRIEF.md
# Shift-Loaded Slot Address Decoder

This block sits beside one slot of a reconfigurable area and decides when the module occupying that slot is addressed by the shared bus. The decision does not come from a fixed comparator. It comes from a small one-bit lookup table indexed by the bus address nibble. One set bit in the table means the slot answers to that one address. Several set bits let a single write reach the slot under several addresses, which gives multicast across slots.

The table is loaded one bit per clock through a serial configuration input while a shift enable is high. After reset, which stands in for power-up or a fresh load of the slot, every table bit is one. In that state the entry for the reserved code is set, so the module is held in reset and receives no select. User logic then shifts in the real pattern, with the reserved entry cleared, to bring the module out of reset.

The nibble value with every bit set never selects anything. A slot that is busy reloading its table also never asserts its select, so an access already under way to another slot is left undisturbed.

Top module: `slot_select_gen`

## Requirements
- R1: While the synchronous active-low reset is low, every table entry is loaded with 1. After reset the module reset output is high and select is low for every address.
- R2: On each clock edge with the shift enable high, the serial input bit enters table index 0 and every other entry moves up one index. The bit at index 15 is dropped. Sixteen such edges replace the whole table, and the first bit shifted in ends up at index 15.
- R3: With the shift enable low and the module reset low, select equals the table entry at the bus address ANDed with the bus enable, for address values 0 to 14.
- R4: The read enable equals select ANDed with the bus read strobe.
- R5: Address value 15 (all ones) never raises select or read enable, whatever the table holds.
- R6: The module reset output equals table entry 15. While it is high, select is low. It changes only on an edge where the shift enable is high, or through reset.
- R7: While the shift enable is high, select and read enable stay low. While the shift enable is low, the serial input has no effect on the table.
- R8: When several table entries are set, select rises for each of those addresses.
- R9: A partial load of fewer than 16 bits keeps the older entries, each moved up by the number of bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table and the shift port |
| rst_n | input | 1 | Synchronous active-low reset; sets the table to all ones |
| cfg_shift_en | input | 1 | Shift enable for the serial table load |
| cfg_din | input | 1 | Serial table data, entering at index 0 |
| bus_en | input | 1 | Bus transaction enable |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Address nibble that indexes the table |
| mod_sel | output | 1 | Module select |
| mod_rd_en | output | 1 | Module read enable |
| mod_rst | output | 1 | Module reset, high while the slot is unconfigured |

## Verification
The bench builds the block with the default 4-bit address, which gives a 16-entry table. With that size, the reserved code 15 can be driven from the bus, and a complete 16-edge reload can be followed end to end. A two-bit pattern puts multicast and single-address decoding into the same vector walk. Shorter loads that follow it show the shift direction, and show the reserved entry being set again so that the slot goes back into reset.

// File: rtl/slot_sel_pkg.sv
// Package: shared types for the slot address decoder.
// Assumes: consumers agree on the default address width below.
package slot_sel_pkg;

    localparam int unsigned DEF_ADDR_W = 4;

    // Control outputs handed from the select logic to the top.
    typedef struct packed {
        logic sel;
        logic rd_en;
        logic rst;
    } slot_ctl_t;

endpackage

// File: rtl/slot_lut_shift.sv
// Module: slot_lut_shift
// Holds the one-bit address table as a shift register. It loads all ones
// on reset and shifts serial data in at index 0 when enabled. It also
// presents the entry at the looked-up address and the reserved top entry.
// Assumes: DEPTH equals 2**ADDR_W, and the shift port uses the bus clock.
module slot_lut_shift #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              top_bit
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] tbl_q;

    // Table register: all ones on reset, shift toward the top when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '1;
        end else if (shift_en) begin
            tbl_q <= {tbl_q[DEPTH-2:0], din};
        end
    end

    // Lookup of the addressed entry and the reserved-code entry.
    always_comb begin
        hit     = tbl_q[addr];
        top_bit = tbl_q[DEPTH-1];
    end

endmodule

// File: rtl/slot_sel_logic.sv
// Module: slot_sel_logic
// Turns the table lookup and the bus strobes into select, read enable and
// module reset. It suppresses the select for the reserved code, during
// shifting, and while the slot is unconfigured.
// Assumes: the reserved code is the all-ones address.
module slot_sel_logic
    import slot_sel_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              hit,
    input  logic              top_bit,
    input  logic              shift_en,
    input  logic              bus_en,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] addr,
    output slot_ctl_t         ctl
);
    localparam logic [ADDR_W-1:0] RESERVED = '1;

    logic addr_ok;

    // Qualify the address: the reserved code never selects.
    always_comb addr_ok = (addr != RESERVED);

    // Build select, read enable and reset from the qualified lookup.
    always_comb begin
        ctl.rst   = top_bit;
        ctl.sel   = hit & bus_en & addr_ok & ~shift_en & ~top_bit;
        ctl.rd_en = ctl.sel & bus_rd;
    end

endmodule

// File: rtl/slot_select_gen.sv
// Module: slot_select_gen (top)
// Per-slot module select generator built from a serially loaded address
// table plus the select, read-enable and reset qualification logic.
// Assumes: one clock serves both the bus and the configuration shift port.
module slot_select_gen
    import slot_sel_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shift_en,
    input  logic              cfg_din,
    input  logic              bus_en,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              mod_sel,
    output logic              mod_rd_en,
    output logic              mod_rst
);
    logic      hit;
    logic      top_bit;
    slot_ctl_t ctl;

    slot_lut_shift #(.ADDR_W(ADDR_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (cfg_din),
        .addr     (bus_addr),
        .hit      (hit),
        .top_bit  (top_bit)
    );

    slot_sel_logic #(.ADDR_W(ADDR_W)) u_sel (
        .hit      (hit),
        .top_bit  (top_bit),
        .shift_en (cfg_shift_en),
        .bus_en   (bus_en),
        .bus_rd   (bus_rd),
        .addr     (bus_addr),
        .ctl      (ctl)
    );

    // Drive the outputs from the packed control word.
    always_comb begin
        mod_sel   = ctl.sel;
        mod_rd_en = ctl.rd_en;
        mod_rst   = ctl.rst;
    end

endmodule

// File: rtl/slot_select_gen_chk.sv
// Module: slot_select_gen_chk
// Checker bound to slot_select_gen. It relates the port behaviour over time.
// Assumes: it is attached through the bind statement at the end of this file.
module slot_select_gen_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_shift_en,
    input logic              bus_en,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              mod_sel,
    input logic              mod_rd_en,
    input logic              mod_rst
);
    localparam logic [ADDR_W-1:0] RESV = '1;

    a_r3_sel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mod_sel |-> bus_en);

    a_r4_rd_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rd_en |-> (mod_sel && bus_rd));

    a_r5_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RESV) |-> !mod_sel);

    a_r6_rst_blocks_sel: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst |-> !mod_sel);

    a_r6_rst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift_en |=> $stable(mod_rst));

    a_r7_shift_blocks_sel: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |-> !mod_sel);

endmodule

bind slot_select_gen slot_select_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_shift_en (cfg_shift_en),
    .bus_en       (bus_en),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .mod_sel      (mod_sel),
    .mod_rd_en    (mod_rd_en),
    .mod_rst      (mod_rst)
);

// File: tb/sim_slot_select_gen.sv
// Bench for slot_select_gen: a vector walk after a full table load, then
// directed tests for reset, shifting, ignored input and partial loads.
module sim_slot_select_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       mod_sel, mod_rd_en, mod_rst;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    slot_select_gen #(.ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en),
        .cfg_din(cfg_din), .bus_en(bus_en), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .mod_sel(mod_sel), .mod_rd_en(mod_rd_en),
        .mod_rst(mod_rst)
    );

    // Vector: {bus_en, bus_rd, addr[3:0], exp_sel, exp_rd}; table = 0x0404.
    localparam logic [7:0] VECS [8] = '{
        {1'b1, 1'b0, 4'd2,  1'b1, 1'b0},  // R3
        {1'b1, 1'b1, 4'd2,  1'b1, 1'b1},  // R4
        {1'b1, 1'b1, 4'd10, 1'b1, 1'b1},  // R8
        {1'b0, 1'b1, 4'd2,  1'b0, 1'b0},  // R3
        {1'b1, 1'b1, 4'd3,  1'b0, 1'b0},  // R3
        {1'b1, 1'b0, 4'd10, 1'b1, 1'b0},  // R8
        {1'b1, 1'b1, 4'd15, 1'b0, 1'b0},  // R5
        {1'b1, 1'b1, 4'd0,  1'b0, 1'b0}   // R3
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic probe(input logic en, input logic rd, input logic [3:0] a);
        @(negedge clk);
        bus_en = en; bus_rd = rd; bus_addr = a;
        #2;
    endtask

    // Shift nbits of w, most significant of those first; checks R7 meanwhile.
    task automatic shift_in(input logic [15:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift_en = 1'b1; cfg_din = w[i];
            bus_en = 1'b1; bus_addr = 4'd2;
            #2;
            check("R7 sel low while shifting", mod_sel, 1'b0);
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: all ones after reset -> module in reset, no select.
        probe(1'b1, 1'b1, 4'd2);
        check("R1 rst after reset", mod_rst, 1'b1);
        check("R1 no sel unconfigured", mod_sel, 1'b0);
        probe(1'b1, 1'b1, 4'd9);
        check("R1 no sel unconfigured", mod_sel, 1'b0);

        // R2: full 16-edge load of 0x0404 (entries 2 and 10).
        shift_in(16'h0404, 16);
        #2;
        check("R2 R6 rst cleared after load", mod_rst, 1'b0);

        for (int k = 0; k < 8; k++) begin
            probe(VECS[k][7], VECS[k][6], VECS[k][5:2]);
            check("R3/R4/R5/R8 vector sel", mod_sel, VECS[k][1]);
            check("R4 vector rd_en", mod_rd_en, VECS[k][0]);
        end

        // R7: serial input ignored while shift enable is low.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) cfg_din = k[0];
        end
        probe(1'b1, 1'b0, 4'd2);
        check("R7 din ignored, entry 2", mod_sel, 1'b1);
        probe(1'b1, 1'b0, 4'd0);
        check("R7 din ignored, entry 0", mod_sel, 1'b0);

        // R9: one-bit partial load of 1 -> table 0x0809.
        shift_in(16'h0001, 1);
        probe(1'b1, 1'b0, 4'd0);
        check("R9 new bit at index 0", mod_sel, 1'b1);
        probe(1'b1, 1'b0, 4'd3);
        check("R9 old entry 2 moved to 3", mod_sel, 1'b1);
        probe(1'b1, 1'b0, 4'd2);
        check("R9 entry 2 now clear", mod_sel, 1'b0);
        probe(1'b1, 1'b0, 4'd11);
        check("R9 old entry 10 moved to 11", mod_sel, 1'b1);
        check("R6 rst still low", mod_rst, 1'b0);

        // R6: four more ones -> 0x809F, top entry set, reset returns.
        shift_in(16'h000F, 4);
        probe(1'b1, 1'b1, 4'd0);
        check("R6 rst when top entry set", mod_rst, 1'b1);
        check("R6 no sel while in reset", mod_sel, 1'b0);

        // R1: mid-operation reset restores all ones.
        shift_in(16'h0404, 16);
        probe(1'b1, 1'b0, 4'd2);
        check("R2 reload selects entry 2", mod_sel, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        probe(1'b1, 1'b0, 4'd2);
        check("R1 rst after second reset", mod_rst, 1'b1);
        check("R1 sel low after second reset", mod_sel, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule